// File: doc/BRIEF.md
# Clock Comparator Store Unit

This block runs the privileged instruction that copies the clock comparator into memory. It keeps a 64-bit comparator register that is loaded through a separate strobe. Only the high-order `CMP_BITS` bits of that register take part in the comparison with the time-of-day clock, so the store forces every bit below them to zero. When an instruction is accepted, the unit first checks the privilege state and then the operand alignment. An accepted store then runs in two phases against the memory side. In the first phase it presents the address and waits for an acknowledge that carries protection and addressing flags. The second phase, a single write strobe that carries the doubleword, happens only when neither flag is set.

Every outcome ends with a one-cycle `done` pulse that carries an exception code. The condition code that the unit received with the instruction is returned unchanged. A suppressed operation never raises the write strobe. The time-of-day comparison, the interrupt logic and the memory itself belong to other blocks.

Top module: `cc_store_unit`

## Requirements
- R1: After reset, `st_req`, `st_we`, `done`, `exc_valid` and `busy` are low, and the comparator register holds zero. A store issued before any load therefore writes zero.
- R2: An instruction accepted with `problem_state` high completes one cycle later with `done` high, `exc_valid` high and `exc_code` = 1 (privileged operation). Neither `st_req` nor `st_we` is raised.
- R3: An instruction accepted in supervisor state whose address has any of its low three bits set completes one cycle later with `exc_code` = 2 (specification). Neither `st_req` nor `st_we` is raised.
- R4: When both the privilege fault and the misalignment are present, the code reported is 1.
- R5: An aligned supervisor instruction raises `st_req` in the cycle after acceptance, with `st_addr` equal to the operand address. Both stay stable until `st_ack` is sampled high.
- R6: If the acknowledge carries no fault flag, `st_we` is high for exactly the next cycle. During that cycle `st_data` equals the comparator value with its low (64 − `CMP_BITS`) bits cleared. `done` follows one cycle later with `exc_code` = 0 and `exc_valid` low.
- R7: An acknowledge with `st_addr_err` high completes the instruction in the next cycle with `exc_code` = 4 (addressing) and no `st_we`. This code wins when `st_prot_err` is also high.
- R8: An acknowledge with only `st_prot_err` high completes the instruction in the next cycle with `exc_code` = 3 (protection) and no `st_we`.
- R9: At `done`, `cc_out` equals the `psw_cc` value that was sampled when the instruction was accepted.
- R10: `insn_valid` is ignored while `busy` is high. It starts no second operation and changes no completion code.
- R11: The stored value is the comparator content at acceptance. A `cmp_load` during the access phase, or in the acceptance cycle itself, does not alter the doubleword that is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_load | input | 1 | Writes `cmp_load_val` into the comparator register |
| cmp_load_val | input | DATA_W | New comparator value |
| insn_valid | input | 1 | Instruction strobe, taken only while idle |
| op_addr | input | ADDR_W | Second-operand byte address |
| problem_state | input | 1 | High when the CPU is not in supervisor state |
| psw_cc | input | CC_W | Condition code at issue |
| st_ack | input | 1 | Memory response for the pending request |
| st_addr_err | input | 1 | Response flag: address not available |
| st_prot_err | input | 1 | Response flag: store protected |
| busy | output | 1 | An accepted store is in progress |
| st_req | output | 1 | Store access request, held until acknowledged |
| st_addr | output | ADDR_W | Doubleword address of the request |
| st_we | output | 1 | One-cycle write strobe |
| st_data | output | DATA_W | Masked comparator doubleword |
| done | output | 1 | One-cycle completion pulse |
| exc_valid | output | 1 | The completion carries an exception |
| exc_code | output | 3 | 0 none, 1 privileged, 2 specification, 3 protection, 4 addressing |
| cc_out | output | CC_W | Condition code returned unchanged |

## Verification
On every cycle, the assertions check the following properties. A fault at issue never reaches the memory side. A request stays stable until it is acknowledged, and its address is always aligned. Masked bits are zero whenever `st_we` is high. A flagged acknowledge never produces a write, and each write is followed by a clean completion.

Other behaviours depend on chosen stimulus and can only be shown by the bench's scenarios. These are the exact doubleword against the comparator snapshot, whether a load during the access was kept out, whether a stray strobe while busy was dropped, and whether the condition code came back unchanged.

// File: rtl/cc_store_pkg.sv
package cc_store_pkg;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_PRIV = 3'd1,
        EXC_SPEC = 3'd2,
        EXC_PROT = 3'd3,
        EXC_ADDR = 3'd4
    } exc_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_WRITE  = 2'd2
    } state_e;

endpackage

// File: rtl/cc_store_precheck.sv
// Issue-time fault screen: privilege first, then operand alignment.
module cc_store_precheck
    import cc_store_pkg::*;
#(
    parameter int ALIGN_BITS = 3
) (
    input  logic                  problem_state,
    input  logic [ALIGN_BITS-1:0] addr_low,
    output exc_e                  code
);
    always_comb begin
        if (problem_state)
            code = EXC_PRIV;
        else if (addr_low != '0)
            code = EXC_SPEC;
        else
            code = EXC_NONE;
    end
endmodule

// File: rtl/cc_store_accchk.sv
// Classifies the memory response; an unavailable address outranks protection.
module cc_store_accchk
    import cc_store_pkg::*;
(
    input  logic addr_err,
    input  logic prot_err,
    output exc_e code
);
    always_comb begin
        if (addr_err)
            code = EXC_ADDR;
        else if (prot_err)
            code = EXC_PROT;
        else
            code = EXC_NONE;
    end
endmodule

// File: rtl/cc_store_mask.sv
// Clears the comparator bit positions that take no part in the comparison.
module cc_store_mask #(
    parameter int DATA_W    = 64,
    parameter int KEEP_BITS = 52
) (
    input  logic [DATA_W-1:0] raw,
    output logic [DATA_W-1:0] masked
);
    localparam int DROP_BITS = DATA_W - KEEP_BITS;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i >= DROP_BITS) begin : g_keep
            assign masked[i] = raw[i];
        end else begin : g_zero
            assign masked[i] = 1'b0;
        end
    end
endmodule

// File: rtl/cc_store_unit.sv
module cc_store_unit
    import cc_store_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int CMP_BITS   = 52,
    parameter int ALIGN_BITS = 3,
    parameter int CC_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_load,
    input  logic [DATA_W-1:0] cmp_load_val,
    input  logic              insn_valid,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              problem_state,
    input  logic [CC_W-1:0]   psw_cc,
    input  logic              st_ack,
    input  logic              st_addr_err,
    input  logic              st_prot_err,
    output logic              busy,
    output logic              st_req,
    output logic [ADDR_W-1:0] st_addr,
    output logic              st_we,
    output logic [DATA_W-1:0] st_data,
    output logic              done,
    output logic              exc_valid,
    output logic [2:0]        exc_code,
    output logic [CC_W-1:0]   cc_out
);

    typedef struct packed {
        state_e            state;
        logic [DATA_W-1:0] cmp;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              req;
        logic              we;
        logic              done;
        logic              exc_valid;
        exc_e              exc;
        logic [CC_W-1:0]   cc;
    } regs_t;

    regs_t r_q, r_d;

    exc_e              pre_code;
    exc_e              acc_code;
    logic [DATA_W-1:0] cmp_masked;

    cc_store_precheck #(.ALIGN_BITS(ALIGN_BITS)) u_pre (
        .problem_state (problem_state),
        .addr_low      (op_addr[ALIGN_BITS-1:0]),
        .code          (pre_code)
    );

    cc_store_accchk u_acc (
        .addr_err (st_addr_err),
        .prot_err (st_prot_err),
        .code     (acc_code)
    );

    cc_store_mask #(.DATA_W(DATA_W), .KEEP_BITS(CMP_BITS)) u_mask (
        .raw    (r_q.cmp),
        .masked (cmp_masked)
    );

    always_comb begin
        r_d           = r_q;
        r_d.we        = 1'b0;
        r_d.done      = 1'b0;
        r_d.exc_valid = 1'b0;
        if (cmp_load)
            r_d.cmp = cmp_load_val;

        case (r_q.state)
            ST_IDLE: begin
                if (insn_valid) begin
                    r_d.cc = psw_cc;
                    if (pre_code != EXC_NONE) begin
                        r_d.done      = 1'b1;
                        r_d.exc_valid = 1'b1;
                        r_d.exc       = pre_code;
                    end else begin
                        r_d.state = ST_ACCESS;
                        r_d.req   = 1'b1;
                        r_d.addr  = op_addr;
                        r_d.data  = cmp_masked;
                        r_d.exc   = EXC_NONE;
                    end
                end
            end
            ST_ACCESS: begin
                if (st_ack) begin
                    r_d.req = 1'b0;
                    if (acc_code != EXC_NONE) begin
                        r_d.state     = ST_IDLE;
                        r_d.done      = 1'b1;
                        r_d.exc_valid = 1'b1;
                        r_d.exc       = acc_code;
                    end else begin
                        r_d.state = ST_WRITE;
                        r_d.we    = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.exc   = EXC_NONE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign st_req    = r_q.req;
    assign st_addr   = r_q.addr;
    assign st_we     = r_q.we;
    assign st_data   = r_q.data;
    assign done      = r_q.done;
    assign exc_valid = r_q.exc_valid;
    assign exc_code  = r_q.exc;
    assign cc_out    = r_q.cc;

endmodule

// File: rtl/cc_store_unit_chk.sv
module cc_store_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int CMP_BITS   = 52,
    parameter int ALIGN_BITS = 3,
    parameter int CC_W       = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_load,
    input logic [DATA_W-1:0] cmp_load_val,
    input logic              insn_valid,
    input logic [ADDR_W-1:0] op_addr,
    input logic              problem_state,
    input logic [CC_W-1:0]   psw_cc,
    input logic              st_ack,
    input logic              st_addr_err,
    input logic              st_prot_err,
    input logic              busy,
    input logic              st_req,
    input logic [ADDR_W-1:0] st_addr,
    input logic              st_we,
    input logic [DATA_W-1:0] st_data,
    input logic              done,
    input logic              exc_valid,
    input logic [2:0]        exc_code,
    input logic [CC_W-1:0]   cc_out
);
    localparam logic [DATA_W-1:0] LOW_ZERO = {DATA_W{1'b1}} >> CMP_BITS;

    p_priv_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_valid && problem_state)
        |=> (done && exc_valid && exc_code == 3'd1 && !st_req && !st_we));

    p_misalign_spec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && insn_valid && !problem_state && op_addr[ALIGN_BITS-1:0] != '0)
        |=> (done && exc_code == 3'd2 && !st_req && !st_we));

    p_req_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_req |-> (st_addr[ALIGN_BITS-1:0] == '0 && busy));

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> (st_req && $stable(st_addr)));

    p_masked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> ((st_data & LOW_ZERO) == '0));

    p_write_then_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |=> (done && !exc_valid && exc_code == 3'd0 && !st_we));

    p_fault_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_ack && st_addr_err) |=> (!st_we && done && exc_code == 3'd4));

    p_prot_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && st_ack && st_prot_err && !st_addr_err)
        |=> (!st_we && done && exc_code == 3'd3));

    p_busy_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !st_ack) |=> !done);
endmodule

bind cc_store_unit cc_store_unit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_BITS(CMP_BITS),
    .ALIGN_BITS(ALIGN_BITS), .CC_W(CC_W)
) u_chk (.*);

// File: tb/cc_store_unit_tb.sv
module cc_store_unit_tb;
    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 64;
    localparam int CMP_BITS = 52;
    localparam int CC_W     = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmp_load = 1'b0;
    logic [DATA_W-1:0] cmp_load_val = '0;
    logic              insn_valid = 1'b0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic              problem_state = 1'b0;
    logic [CC_W-1:0]   psw_cc = '0;
    logic              st_ack = 1'b0;
    logic              st_addr_err = 1'b0;
    logic              st_prot_err = 1'b0;
    logic              busy, st_req, st_we, done, exc_valid;
    logic [ADDR_W-1:0] st_addr;
    logic [DATA_W-1:0] st_data;
    logic [2:0]        exc_code;
    logic [CC_W-1:0]   cc_out;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] cur_cmp = '0;

    always #10 clk = ~clk;

    cc_store_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_BITS(CMP_BITS), .CC_W(CC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_load(cmp_load), .cmp_load_val(cmp_load_val),
        .insn_valid(insn_valid), .op_addr(op_addr), .problem_state(problem_state),
        .psw_cc(psw_cc), .st_ack(st_ack), .st_addr_err(st_addr_err),
        .st_prot_err(st_prot_err), .busy(busy), .st_req(st_req), .st_addr(st_addr),
        .st_we(st_we), .st_data(st_data), .done(done), .exc_valid(exc_valid),
        .exc_code(exc_code), .cc_out(cc_out)
    );

    function automatic logic [DATA_W-1:0] expect_data(logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] o = v;
        for (int i = 0; i < DATA_W - CMP_BITS; i++) o[i] = 1'b0;
        return o;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_cmp(input logic [DATA_W-1:0] v);
        @(negedge clk);
        cmp_load = 1'b1; cmp_load_val = v;
        @(negedge clk);
        cmp_load = 1'b0;
        cur_cmp = v;
    endtask

    task automatic do_op(input logic [ADDR_W-1:0] a, input bit pr, input logic [CC_W-1:0] cc,
                         input int dly, input bit ae, input bit pe, input bit poke);
        logic [DATA_W-1:0] exp_d;
        @(negedge clk);
        insn_valid = 1'b1; op_addr = a; problem_state = pr; psw_cc = cc;
        exp_d = expect_data(cur_cmp);
        @(negedge clk);
        insn_valid = 1'b0; problem_state = 1'b0;
        if (pr) begin
            check(done && exc_valid && exc_code == 3'd1 && !st_req && !st_we,
                  (a[2:0] != 0) ? "R4 priv over spec" : "R2 priv", {61'd0, exc_code}, 64'd1);
            check(cc_out == cc, "R9 cc on priv", {62'd0, cc_out}, {62'd0, cc});
        end else if (a[2:0] != 3'd0) begin
            check(done && exc_valid && exc_code == 3'd2 && !st_req && !st_we,
                  "R3 spec", {61'd0, exc_code}, 64'd2);
        end else begin
            check(st_req && busy && st_addr == a, "R5 request", {32'd0, st_addr}, {32'd0, a});
            for (int k = 0; k < dly; k++) begin
                if (poke && k == 0) begin
                    insn_valid = 1'b1; problem_state = 1'b1;
                    cmp_load = 1'b1; cmp_load_val = ~cur_cmp;
                end
                @(negedge clk);
                if (poke && k == 0) begin
                    insn_valid = 1'b0; problem_state = 1'b0; cmp_load = 1'b0;
                    cur_cmp = cmp_load_val;
                end
                check(st_req && !done && st_addr == a, "R5 held", {32'd0, st_addr}, {32'd0, a});
            end
            st_ack = 1'b1; st_addr_err = ae; st_prot_err = pe;
            @(negedge clk);
            st_ack = 1'b0; st_addr_err = 1'b0; st_prot_err = 1'b0;
            if (ae) begin
                check(done && exc_code == 3'd4 && !st_we && !st_req, "R7 addressing",
                      {61'd0, exc_code}, 64'd4);
            end else if (pe) begin
                check(done && exc_code == 3'd3 && !st_we && !st_req, "R8 protection",
                      {61'd0, exc_code}, 64'd3);
            end else begin
                check(st_we && !done, "R6 write strobe", {63'd0, st_we}, 64'd1);
                check(st_data == exp_d, poke ? "R11 snapshot data" : "R6 masked data", st_data, exp_d);
                @(negedge clk);
                check(done && !exc_valid && exc_code == 3'd0 && !st_we,
                      poke ? "R10 ignored while busy" : "R6 clean done", {61'd0, exc_code}, 64'd0);
                check(cc_out == cc, "R9 cc unchanged", {62'd0, cc_out}, {62'd0, cc});
                @(negedge clk);
                check(!done && !busy, "R10 no extra op", {63'd0, done}, 64'd0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!st_req && !st_we && !done && !exc_valid && !busy, "R1 reset outputs",
              {59'd0, st_req, st_we, done, exc_valid, busy}, 64'd0);
        do_op(32'h0000_1000, 1'b0, 2'd1, 0, 1'b0, 1'b0, 1'b0);   // R1: zero stored

        load_cmp(64'hFFFF_FFFF_FFFF_FFFF);
        do_op(32'h0000_2008, 1'b0, 2'd2, 1, 1'b0, 1'b0, 1'b0);
        do_op(32'h0000_2004, 1'b0, 2'd0, 0, 1'b0, 1'b0, 1'b0);
        do_op(32'h0000_2001, 1'b1, 2'd3, 0, 1'b0, 1'b0, 1'b0);
        do_op(32'h0000_2000, 1'b1, 2'd1, 0, 1'b0, 1'b0, 1'b0);
        do_op(32'h0000_3000, 1'b0, 2'd1, 2, 1'b1, 1'b1, 1'b0);
        do_op(32'h0000_3008, 1'b0, 2'd2, 0, 1'b0, 1'b1, 1'b0);
        load_cmp(64'h0123_4567_89AB_CDEF);
        do_op(32'h0000_4000, 1'b0, 2'd3, 2, 1'b0, 1'b0, 1'b1);

        // R11: load in the acceptance cycle keeps the old value
        @(negedge clk);
        cmp_load = 1'b1; cmp_load_val = 64'h5555_5555_5555_5555;
        insn_valid = 1'b1; op_addr = 32'h10; problem_state = 1'b0; psw_cc = 2'd0;
        @(negedge clk);
        cmp_load = 1'b0; insn_valid = 1'b0;
        st_ack = 1'b1;
        @(negedge clk);
        st_ack = 1'b0;
        check(st_we && st_data == expect_data(cur_cmp), "R11 same-cycle load",
              st_data, expect_data(cur_cmp));
        cur_cmp = 64'h5555_5555_5555_5555;
        @(negedge clk);

        for (int n = 0; n < 60; n++) begin
            logic [ADDR_W-1:0] a;
            int r;
            r = $urandom_range(0, 9);
            if (r == 0) load_cmp({$urandom, $urandom});
            a = $urandom;
            if ($urandom_range(0, 2) != 0) a[2:0] = 3'd0;
            do_op(a, ($urandom_range(0, 5) == 0), 2'($urandom_range(0, 3)),
                  $urandom_range(0, 3), ($urandom_range(0, 6) == 0),
                  ($urandom_range(0, 6) == 0), ($urandom_range(0, 4) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule